// File: doc/BRIEF.md
# DRAM Power-Up Reset and Clock-Enable Sequencer

This block owns the DRAM reset pin, the DRAM clock-enable (CKE) pin and the enable for the memory clock during bring-up. Firmware or a boot controller pulses a start strobe once. At that moment it also gives a flag saying whether the device came up from power-on (cold) or from a restart that left the memory in self-refresh (warm), and a wait count in clock cycles. On the cold path the block keeps reset low for a fixed hold time and then releases it. It starts the memory clock a fixed lead time before CKE and raises CKE only after the programmed wait. The wait is never shorter than a floor set by a parameter. With the default 250 MHz clock that floor is 500 µs.

On the warm path the memory was left in self-refresh with its reset high. The block never lowers the DRAM reset on this path, not even for a single cycle. It starts the memory clock at once and raises CKE a lead time later, which brings the memory out of self-refresh. When the system reset is asserted with the warm flag set, the DRAM reset pin keeps whatever level it had. A done flag follows CKE by one cycle and stays high until the next system reset. Mode-register setup and calibration come later, outside this block.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: On every clock edge where `rst_n` is low, `dram_cke_o`, `mem_clk_en_o` and `done_o` are cleared. `dram_rst_n_o` is cleared if `warm_i` is 0 and keeps its previous value if `warm_i` is 1.
- R2: After reset is released and before a start strobe, all four outputs keep their values.
- R3: On a cold start (`warm_i`=0 at the edge where `start_i` is sampled high, called edge 0), `dram_rst_n_o` is low after edges 0 to HOLD_CYC-1 and rises at edge HOLD_CYC.
- R4: On a cold start, `dram_cke_o` rises exactly G edges after `dram_rst_n_o` rises. G = max(delay_cnt_i sampled at edge 0, MIN_GAP_CYC, CLK_LEAD+1).
- R5: On a cold start, `mem_clk_en_o` rises CLK_LEAD edges before `dram_cke_o` rises.
- R6: On a warm start (`warm_i`=1 at edge 0), `dram_rst_n_o` never goes low. `mem_clk_en_o` rises at edge 0 and `dram_cke_o` rises at edge CLK_LEAD.
- R7: `done_o` rises one edge after `dram_cke_o`. After that, `done_o`, `dram_cke_o`, `mem_clk_en_o` and `dram_rst_n_o` stay high until the next system reset.
- R8: `warm_i` and `delay_cnt_i` are used only at edge 0. Later changes to them, and further start strobes, have no effect on the outputs until the next system reset.
- R9: `dram_cke_o` never rises unless `dram_rst_n_o` and `mem_clk_en_o` are both already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | System reset, synchronous, active low |
| warm_i | input | 1 | 1 = warm restart (memory in self-refresh), 0 = cold start |
| start_i | input | 1 | Start strobe, acted on only while idle |
| delay_cnt_i | input | CNT_W | Reset-to-CKE wait in clock cycles |
| dram_rst_n_o | output | 1 | DRAM reset pin, active low |
| dram_cke_o | output | 1 | DRAM clock-enable pin |
| mem_clk_en_o | output | 1 | Enable for the memory clock output |
| done_o | output | 1 | Power-up sequence complete |

## Verification
A state machine stuck in the wrong state, or a counter loaded with the wrong value, shows up as an output edge in the wrong cycle. The sweep over wait counts on both paths therefore compares the exact cycle of each rising edge with the arithmetic expectation, and the result is known within one sequence. A warm run that takes a cold branch shows at once as a low cycle on the DRAM reset pin. A latch that is loaded late shows as a shifted CKE edge in the runs where the inputs change after the start. A checker also measures the spacing from reset to CKE with its own counter, so a short wait is reported at the edge where CKE rises.

// File: rtl/ddr_pwrup_pkg.sv
// Package: shared state encoding for the DRAM power-up sequencer.
// Assumes: used by every module of ddr_pwrup_seq.
package ddr_pwrup_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE      = 3'd0,
        SEQ_HOLD_LOW  = 3'd1,
        SEQ_RST_WAIT  = 3'd2,
        SEQ_CKE_HIGH  = 3'd3,
        SEQ_WARM_CLK  = 3'd4,
        SEQ_DONE      = 3'd5
    } seq_state_t;

endpackage

// File: rtl/ddr_pwrup_timer.sv
// Module: down-counter that times every wait phase of the sequencer.
// Does:   loads a value on load_i, then decrements once per tick_i until zero.
// Assumes: load_i and tick_i are never both needed to act in the same cycle
//          (the load wins).
module ddr_pwrup_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    input  logic          tick_i,
    output logic [TW-1:0] cnt_o,
    output logic          zero_o
);

    logic [TW-1:0] cnt_q;

    // Load the phase length or count the current phase down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_pwrup_fsm.sv
// Module: phase controller of the DRAM power-up sequence.
// Does:   picks the cold or warm branch at the start strobe, latches the wait
//         count, orders the phases and asks the timer for each phase length.
//         It also flags the cycle in which the memory clock must be enabled.
// Assumes: HOLD_CYC >= 1, CLK_LEAD >= 1, FLOOR_CYC >= CLK_LEAD + 1, and every
//          one of these fits in TW bits.
module ddr_pwrup_fsm
    import ddr_pwrup_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int TW        = 8,
    parameter int HOLD_CYC  = 4,
    parameter int CLK_LEAD  = 8,
    parameter int FLOOR_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [TW-1:0]    cnt_i,
    input  logic             zero_i,
    output seq_state_t       nxt_state_o,
    output logic             load_o,
    output logic [TW-1:0]    load_val_o,
    output logic             tick_o,
    output logic             clk_set_o
);

    localparam logic [TW-1:0] HOLD_LOAD  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] LEAD_LOAD  = TW'(CLK_LEAD - 1);
    localparam logic [TW-1:0] LEAD_MARK  = TW'(CLK_LEAD);
    localparam logic [TW-1:0] FLOOR_VAL  = TW'(FLOOR_CYC);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [CNT_W-1:0] delay_q;
    logic [TW-1:0]    gap_cyc;
    logic             take_start;

    assign take_start = (state_q == SEQ_IDLE) && start_i;

    // Spacing from reset release to CKE: the latched count, raised to the floor.
    always_comb begin
        if (TW'(delay_q) > FLOOR_VAL) begin
            gap_cyc = TW'(delay_q);
        end else begin
            gap_cyc = FLOOR_VAL;
        end
    end

    // Next phase and timer load for each phase.
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    load_o = 1'b1;
                    if (warm_i) begin
                        state_d    = SEQ_WARM_CLK;
                        load_val_o = LEAD_LOAD;
                    end else begin
                        state_d    = SEQ_HOLD_LOW;
                        load_val_o = HOLD_LOAD;
                    end
                end
            end
            SEQ_HOLD_LOW: begin
                if (zero_i) begin
                    state_d    = SEQ_RST_WAIT;
                    load_o     = 1'b1;
                    load_val_o = gap_cyc - 1'b1;
                end
            end
            SEQ_RST_WAIT: begin
                if (zero_i) begin
                    state_d = SEQ_CKE_HIGH;
                end
            end
            SEQ_WARM_CLK: begin
                if (zero_i) begin
                    state_d = SEQ_CKE_HIGH;
                end
            end
            SEQ_CKE_HIGH: begin
                state_d = SEQ_DONE;
            end
            SEQ_DONE: begin
                state_d = SEQ_DONE;
            end
            default: begin
                state_d = SEQ_IDLE;
            end
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the wait count once, at the accepted start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_q <= '0;
        end else if (take_start) begin
            delay_q <= delay_i;
        end
    end

    assign tick_o = ((state_q == SEQ_HOLD_LOW) || (state_q == SEQ_RST_WAIT) ||
                     (state_q == SEQ_WARM_CLK)) && !load_o;

    // Clock enable: at once on the warm branch, CLK_LEAD cycles before CKE on the cold branch.
    assign clk_set_o = (take_start && warm_i) ||
                       ((state_q == SEQ_RST_WAIT) && (cnt_i == LEAD_MARK));

    assign nxt_state_o = state_d;

endmodule

// File: rtl/ddr_pwrup_pins.sv
// Module: registered drivers for the DRAM reset, CKE, memory clock enable
//         and done outputs.
// Does:   registers each pin from the next phase, so every pin changes on the
//         same edge as the phase. During a warm system reset it leaves the
//         DRAM reset pin untouched.
// Assumes: the next phase comes from ddr_pwrup_fsm.
module ddr_pwrup_pins
    import ddr_pwrup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_i,
    input  seq_state_t nxt_state_i,
    input  logic       clk_set_i,
    output logic       dram_rst_n_o,
    output logic       dram_cke_o,
    output logic       mem_clk_en_o,
    output logic       done_o
);

    logic rst_pin_q;
    logic cke_q;
    logic clk_en_q;
    logic done_q;

    // DRAM reset pin: low for the hold phase, high from reset release on, held on warm reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pin_q <= warm_i ? rst_pin_q : 1'b0;
        end else if (nxt_state_i == SEQ_HOLD_LOW) begin
            rst_pin_q <= 1'b0;
        end else if (nxt_state_i == SEQ_RST_WAIT) begin
            rst_pin_q <= 1'b1;
        end
    end

    // CKE and done follow the final phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cke_q  <= (nxt_state_i == SEQ_CKE_HIGH) || (nxt_state_i == SEQ_DONE);
            done_q <= (nxt_state_i == SEQ_DONE);
        end
    end

    // Memory clock enable: set once, held until system reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
        end else begin
            clk_en_q <= clk_en_q | clk_set_i;
        end
    end

    assign dram_rst_n_o = rst_pin_q;
    assign dram_cke_o   = cke_q;
    assign mem_clk_en_o = clk_en_q;
    assign done_o       = done_q;

endmodule

// File: rtl/ddr_pwrup_seq.sv
// Module: DRAM power-up reset / CKE sequencer (top).
// Does:   on start, runs either the cold branch (hold reset low, release it,
//         wait at least the floor, then CKE) or the warm branch (clock on,
//         then CKE, reset never touched), then raises done.
// Assumes: synchronous active-low system reset; MIN_GAP_CYC is the reset-to-CKE
//          floor in cycles of clk (125000 = 500 us at 250 MHz); HOLD_CYC >= 1,
//          CLK_LEAD >= 1.
module ddr_pwrup_seq #(
    parameter int CNT_W       = 18,
    parameter int HOLD_CYC    = 4,
    parameter int CLK_LEAD    = 8,
    parameter int MIN_GAP_CYC = 125000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] delay_cnt_i,
    output logic             dram_rst_n_o,
    output logic             dram_cke_o,
    output logic             mem_clk_en_o,
    output logic             done_o
);

    import ddr_pwrup_pkg::*;

    localparam int FLOOR_CYC = (MIN_GAP_CYC > CLK_LEAD + 1) ? MIN_GAP_CYC : CLK_LEAD + 1;
    localparam int W_FLOOR   = $clog2(FLOOR_CYC + 1);
    localparam int W_HOLD    = $clog2(HOLD_CYC + 1);
    localparam int W_A       = (W_FLOOR > CNT_W) ? W_FLOOR : CNT_W;
    localparam int TW        = (W_A > W_HOLD) ? W_A : W_HOLD;

    seq_state_t    nxt_state;
    logic          t_load;
    logic [TW-1:0] t_load_val;
    logic          t_tick;
    logic [TW-1:0] t_cnt;
    logic          t_zero;
    logic          clk_set;

    ddr_pwrup_fsm #(
        .CNT_W     (CNT_W),
        .TW        (TW),
        .HOLD_CYC  (HOLD_CYC),
        .CLK_LEAD  (CLK_LEAD),
        .FLOOR_CYC (FLOOR_CYC)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .warm_i      (warm_i),
        .start_i     (start_i),
        .delay_i     (delay_cnt_i),
        .cnt_i       (t_cnt),
        .zero_i      (t_zero),
        .nxt_state_o (nxt_state),
        .load_o      (t_load),
        .load_val_o  (t_load_val),
        .tick_o      (t_tick),
        .clk_set_o   (clk_set)
    );

    ddr_pwrup_timer #(
        .TW (TW)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_load_val),
        .tick_i     (t_tick),
        .cnt_o      (t_cnt),
        .zero_o     (t_zero)
    );

    ddr_pwrup_pins pins_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .warm_i       (warm_i),
        .nxt_state_i  (nxt_state),
        .clk_set_i    (clk_set),
        .dram_rst_n_o (dram_rst_n_o),
        .dram_cke_o   (dram_cke_o),
        .mem_clk_en_o (mem_clk_en_o),
        .done_o       (done_o)
    );

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
// Module: assertion checker for ddr_pwrup_seq, attached by bind.
// Does:   checks pin ordering, persistence and the reset-to-CKE spacing,
//         which it measures with its own counter.
// Assumes: sees only the top-level ports of ddr_pwrup_seq.
module ddr_pwrup_seq_chk #(
    parameter int CLK_LEAD    = 8,
    parameter int MIN_GAP_CYC = 125000
) (
    input logic clk,
    input logic rst_n,
    input logic dram_rst_n_o,
    input logic dram_cke_o,
    input logic mem_clk_en_o,
    input logic done_o
);

    localparam int FLOOR_CYC = (MIN_GAP_CYC > CLK_LEAD + 1) ? MIN_GAP_CYC : CLK_LEAD + 1;

    logic [31:0] gap_q;
    logic        seen_low_q;
    logic        was_rst_q;

    // Count cycles with reset high and CKE low since the reset pin was last low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q      <= '0;
            seen_low_q <= 1'b0;
        end else if (!dram_rst_n_o) begin
            gap_q      <= '0;
            seen_low_q <= 1'b1;
        end else if (!dram_cke_o && (gap_q != 32'hFFFF_FFFF)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Note whether the last edge saw system reset.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
    end

    // After a reset edge the controlled pins are quiet.
    always @(negedge clk) begin
        if (was_rst_q === 1'b1) begin
            assert_reset_quiet_R1: assert (!dram_cke_o && !mem_clk_en_o && !done_o);
        end
    end

    assert_cke_needs_rst_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cke_o) |-> (dram_rst_n_o && mem_clk_en_o));

    assert_done_follows_cke_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cke_o) |=> done_o);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && dram_cke_o && mem_clk_en_o && dram_rst_n_o));

    assert_cke_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cke_o |=> dram_cke_o);

    assert_gap_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dram_cke_o) && seen_low_q) |-> (gap_q >= 32'(FLOOR_CYC)));

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
    .CLK_LEAD    (CLK_LEAD),
    .MIN_GAP_CYC (MIN_GAP_CYC)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dram_rst_n_o (dram_rst_n_o),
    .dram_cke_o   (dram_cke_o),
    .mem_clk_en_o (mem_clk_en_o),
    .done_o       (done_o)
);

// File: tb/ddr_pwrup_seq_tb.sv
// Bench: sweeps the wait count over a scaled-down configuration on both the
//        cold and the warm branch. It records the cycle of every output edge
//        and compares it with arithmetic expectations.
module ddr_pwrup_seq_tb_top;

    localparam int W    = 6;
    localparam int H    = 3;
    localparam int L    = 2;
    localparam int MG   = 5;
    localparam int FLR  = (MG > L + 1) ? MG : L + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         warm = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] delay = '0;
    logic         dram_rst_n;
    logic         dram_cke;
    logic         clk_en;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ddr_pwrup_seq #(
        .CNT_W       (W),
        .HOLD_CYC    (H),
        .CLK_LEAD    (L),
        .MIN_GAP_CYC (MG)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .warm_i       (warm),
        .start_i      (start),
        .delay_cnt_i  (delay),
        .dram_rst_n_o (dram_rst_n),
        .dram_cke_o   (dram_cke),
        .mem_clk_en_o (clk_en),
        .done_o       (done)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_pins(input string req, input int r, input int k, input int c, input int d);
        check_eq(req, "dram_rst_n", int'(dram_rst_n), r);
        check_eq(req, "cke", int'(dram_cke), k);
        check_eq(req, "clk_en", int'(clk_en), c);
        check_eq(req, "done", int'(done), d);
    endtask

    // Apply system reset for three edges with the given warm flag; return at a negedge.
    task automatic do_reset(input bit w);
        @(negedge clk);
        warm  = w;
        start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run one sequence and compare the edge cycles; edge 0 is the start edge.
    task automatic run_seq(input bit w, input int d, input bit disturb);
        int first_rst, first_cke, first_clk, first_done, last_low, n_low, n_cke, lim, g;
        string tg;
        g  = (d > FLR) ? d : FLR;
        lim = w ? (L + 8) : (H + g + 8);
        tg = disturb ? " (R8 inputs disturbed)" : "";
        first_rst = -1; first_cke = -1; first_clk = -1; first_done = -1;
        last_low = -1; n_low = 0; n_cke = 0;
        warm  = w;
        delay = W'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < lim; n++) begin
            if (dram_rst_n && first_rst < 0) first_rst = n;
            if (!dram_rst_n) begin last_low = n; n_low++; end
            if (dram_cke) begin n_cke++; if (first_cke < 0) first_cke = n; end
            if (clk_en && first_clk < 0) first_clk = n;
            if (done && first_done < 0) first_done = n;
            if (dram_cke && !(dram_rst_n && clk_en)) begin
                n_checks++; n_fail++;
                $display("FAIL R9 cke high without rst/clk actual=%0d expected=1", int'(dram_rst_n && clk_en));
            end
            if (disturb && n == 1) begin
                warm  = ~w;
                delay = ~W'(d);
                start = 1'b1;
            end
            if (disturb && n == 2) start = 1'b0;
            @(negedge clk);
        end
        if (!w) begin
            check_eq({"R3", tg}, "last low cycle", last_low, H - 1);
            check_eq({"R3", tg}, "rst rise cycle", first_rst, H);
            check_eq({"R4", tg}, "cke rise cycle", first_cke, H + g);
            check_eq({"R5", tg}, "clk_en rise cycle", first_clk, H + g - L);
            check_eq({"R7", tg}, "done rise cycle", first_done, H + g + 1);
            check_eq({"R7", tg}, "cke high cycles", n_cke, lim - (H + g));
        end else begin
            check_eq({"R6", tg}, "rst low cycles", n_low, 0);
            check_eq({"R6", tg}, "clk_en rise cycle", first_clk, 0);
            check_eq({"R6", tg}, "cke rise cycle", first_cke, L);
            check_eq({"R7", tg}, "done rise cycle", first_done, L + 1);
            check_eq({"R7", tg}, "cke high cycles", n_cke, lim - L);
        end
        check_pins({"R7", tg}, 1, 1, 1, 1);
        warm = w;
    endtask

    // Idle without a start and confirm the pins hold.
    task automatic idle_hold(input int r);
        for (int i = 0; i < 4; i++) begin
            delay = W'(i * 7);
            @(negedge clk);
            check_pins("R2", r, 0, 0, 0);
        end
    endtask

    initial begin
        // Reset with warm=1 right after a cold reset keeps the pin low.
        do_reset(1'b0);
        check_pins("R1", 0, 0, 0, 0);
        do_reset(1'b1);
        check_pins("R1", 0, 0, 0, 0);
        for (int d = 0; d <= 21; d++) begin
            int dv;
            dv = (d == 21) ? 63 : d;
            do_reset(1'b0);
            check_pins("R1", 0, 0, 0, 0);
            idle_hold(0);
            run_seq(1'b0, dv, (d % 2) == 1);
            do_reset(1'b1);
            check_pins("R1", 1, 0, 0, 0);
            idle_hold(1);
            run_seq(1'b1, dv, (d % 3) == 0);
        end
        // A cold start after a warm reset pulses reset again.
        do_reset(1'b1);
        run_seq(1'b0, 9, 1'b0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule